// File: doc/BRIEF.md
# DMA Channel Completion Status and Interrupt Logic

This block tracks the completion state of every channel of a multi-channel DMA controller. For each channel it counts the bytes that the data path reports per beat against a transaction byte count loaded at the start of a transaction. When the total is reached on a beat with a good response, the channel's end status is set. When the total is reached with a bad response, a separate error flag is set instead.

In linked-descriptor mode, two further rules apply. If descriptor writeback is enabled, the end status waits for the writeback-done pulse. If a fetched descriptor header has its valid bit clear, a descriptor-invalid status is set, and the header's interrupt-mask bit is latched with it.

Each channel drives its own interrupt line. The line is high while the end status is set and the channel's end-mask configuration bit is low. It is also high while the descriptor-invalid status is set and the latched header mask is low. All status bits are sticky until software clears them.

Top module: `dma_end_irq_top`

## Requirements
- R1: After reset, all end, descriptor-invalid, error and interrupt outputs of all channels are 0.
- R2: With writeback deferral off, a beat with response code 2'b00 (OKAY) that takes the channel's running byte count to or past the loaded total sets that channel's end status in the next cycle. Earlier beats leave the end status at 0.
- R3: A completing beat with any response code other than 2'b00 sets the channel's error flag and leaves its end status at 0.
- R4: The interrupt line is driven by the end status only while the channel's end-mask input is 0. Changing the mask takes effect in the same cycle.
- R5: When link mode and writeback are both enabled for a channel, a good completion does not set the end status. The end status sets in the cycle after the writeback-done pulse. A writeback-done pulse with no completion pending has no effect.
- R6: A descriptor-done pulse with the valid bit at 0 sets the descriptor-invalid status in the next cycle, but only in link mode. A pulse with the valid bit at 1, or outside link mode, leaves that status unchanged.
- R7: The descriptor-invalid status drives the interrupt line only if the header mask bit captured with it was 0.
- R8: Loading a new byte count restarts the running count from zero and leaves all status bits unchanged.
- R9: If a clear and a set for the current transaction arrive in the same cycle, the set wins. If a clear arrives in the same cycle as a deferred writeback completion that belongs to a transaction replaced by a newer load, the clear wins.
- R10: Status bits, and the interrupt they drive, stay set until their clear input is pulsed.
- R11: Every channel's status and interrupt are independent of activity on other channels.
- R12: Beats on a channel with no transaction armed are ignored. This covers beats before any load and beats after the completing beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | NUM_CH | Per-channel pulse: load a new transaction byte count |
| load_cnt_i | input | NUM_CH*CNT_W | Per-channel transaction byte count |
| beat_vld_i | input | NUM_CH | Per-channel pulse: one data beat finished |
| beat_bytes_i | input | NUM_CH*BEAT_W | Per-channel byte count of the beat |
| beat_resp_i | input | NUM_CH*2 | Per-channel beat response code, 2'b00 = OKAY |
| link_i | input | NUM_CH | Per-channel link-mode enable |
| wb_en_i | input | NUM_CH | Per-channel descriptor writeback enable |
| wb_done_i | input | NUM_CH | Per-channel pulse: descriptor writeback finished |
| desc_done_i | input | NUM_CH | Per-channel pulse: descriptor header fetched |
| desc_vld_i | input | NUM_CH | Per-channel header valid bit |
| desc_mask_i | input | NUM_CH | Per-channel header interrupt mask bit |
| end_mask_i | input | NUM_CH | Per-channel end-interrupt mask |
| clr_end_i | input | NUM_CH | Per-channel pulse: clear end status |
| clr_der_i | input | NUM_CH | Per-channel pulse: clear descriptor-invalid status |
| clr_err_i | input | NUM_CH | Per-channel pulse: clear error flag |
| end_o | output | NUM_CH | End status |
| der_o | output | NUM_CH | Descriptor-invalid status |
| err_o | output | NUM_CH | Error-response flag |
| irq_o | output | NUM_CH | Per-channel interrupt line |

## Verification
The byte counter is driven with a total split over several beats, with a single beat that overshoots the total, and with a completing beat that carries an error code. These cases separate exact and overshoot completion, and they separate end from error. Deferred completion is driven with and without a pending transfer. This shows that only a real completion is released by writeback. A partial count is replaced by a new load and then finished, which shows whether the counter restarts. Clear pulses coincide once with a current completion and once with a stale writeback, which checks both sides of the priority rule. Descriptor headers are presented with valid and invalid bits, with each mask value, and outside link mode.

// File: rtl/dma_end_pkg.sv
package dma_end_pkg;
  localparam int RESP_W = 2;

  typedef enum logic [RESP_W-1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/dma_end_byte_cnt.sv
module dma_end_byte_cnt
  import dma_end_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              beat_vld_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  input  resp_e             beat_resp_i,
  output logic              fin_ok_o,
  output logic              fin_bad_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] total_q, cnt_q;
  logic             armed_q;
  logic [SUM_W-1:0] sum;
  logic             take, hit;

  assign take = armed_q & beat_vld_i & ~load_i;
  assign sum  = {1'b0, cnt_q} + {{(SUM_W-BEAT_W){1'b0}}, beat_bytes_i};
  assign hit  = take & (sum >= {1'b0, total_q});

  assign fin_ok_o  = hit & (beat_resp_i == RESP_OKAY);
  assign fin_bad_o = hit & (beat_resp_i != RESP_OKAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      // new transaction: counter restarts, status untouched
      total_q <= load_cnt_i;
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (hit) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (take) begin
      cnt_q   <= sum[CNT_W-1:0];
    end
  end

  p_one_fin_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_ok_o || fin_bad_o) |=> !(fin_ok_o || fin_bad_o) || $past(load_i) || $rose(armed_q));

  p_fin_disarms_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_ok_o || fin_bad_o) |=> !armed_q);

  p_load_arms_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> armed_q && (cnt_q == '0));
endmodule

// File: rtl/dma_end_status.sv
module dma_end_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fin_ok_i,
  input  logic fin_bad_i,
  input  logic load_i,
  input  logic link_i,
  input  logic wb_en_i,
  input  logic wb_done_i,
  input  logic desc_done_i,
  input  logic desc_vld_i,
  input  logic desc_mask_i,
  input  logic end_mask_i,
  input  logic clr_end_i,
  input  logic clr_der_i,
  input  logic clr_err_i,
  output logic end_o,
  output logic der_o,
  output logic err_o,
  output logic irq_o
);
  logic end_q, der_q, err_q, dim_q;
  logic wb_pend_q, wb_stale_q;
  logic defer, end_cur, end_stale, wb_fire, der_set;

  assign defer     = link_i & wb_en_i;
  assign wb_fire   = wb_done_i & wb_pend_q;
  assign end_cur   = (fin_ok_i & ~defer) | (wb_fire & ~wb_stale_q);
  assign end_stale = wb_fire & wb_stale_q;
  assign der_set   = desc_done_i & link_i & ~desc_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q      <= 1'b0;
      der_q      <= 1'b0;
      err_q      <= 1'b0;
      dim_q      <= 1'b0;
      wb_pend_q  <= 1'b0;
      wb_stale_q <= 1'b0;
    end else begin
      // current-transaction set beats clear; stale writeback loses to clear
      if (end_cur)                      end_q <= 1'b1;
      else if (clr_end_i)               end_q <= 1'b0;
      else if (end_stale)               end_q <= 1'b1;

      if (der_set) begin
        der_q <= 1'b1;
        dim_q <= desc_mask_i;
      end else if (clr_der_i) begin
        der_q <= 1'b0;
      end

      if (fin_bad_i)                    err_q <= 1'b1;
      else if (clr_err_i)               err_q <= 1'b0;

      if (fin_ok_i && defer) begin
        wb_pend_q  <= 1'b1;
        wb_stale_q <= 1'b0;
      end else if (wb_fire) begin
        wb_pend_q  <= 1'b0;
        wb_stale_q <= 1'b0;
      end else if (load_i && wb_pend_q) begin
        wb_stale_q <= 1'b1;
      end
    end
  end

  assign end_o = end_q;
  assign der_o = der_q;
  assign err_o = err_q;
  assign irq_o = (end_q & ~end_mask_i) | (der_q & ~dim_q);

  p_end_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_q) |-> $past((fin_ok_i && !(link_i && wb_en_i)) || (wb_done_i && wb_pend_q)));

  p_err_not_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_bad_i && !end_q && !wb_done_i) |=> !end_q && err_q);

  p_end_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_q && !clr_end_i) |=> end_q);

  p_load_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && end_q && !clr_end_i) |=> end_q);

  p_der_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_done_i && link_i && !desc_vld_i) |=> der_q);

  p_der_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!der_q && !(desc_done_i && link_i)) |=> !der_q);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_ok_i && !(link_i && wb_en_i) && clr_end_i) |=> end_q);

  p_irq_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_mask_i && !der_q) |-> !irq_o);
endmodule

// File: rtl/dma_end_chan.sv
module dma_end_chan
  import dma_end_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int BEAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              beat_vld_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  input  logic [RESP_W-1:0] beat_resp_i,
  input  logic              link_i,
  input  logic              wb_en_i,
  input  logic              wb_done_i,
  input  logic              desc_done_i,
  input  logic              desc_vld_i,
  input  logic              desc_mask_i,
  input  logic              end_mask_i,
  input  logic              clr_end_i,
  input  logic              clr_der_i,
  input  logic              clr_err_i,
  output logic              end_o,
  output logic              der_o,
  output logic              err_o,
  output logic              irq_o
);
  logic fin_ok, fin_bad;

  dma_end_byte_cnt #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .load_cnt_i   (load_cnt_i),
    .beat_vld_i   (beat_vld_i),
    .beat_bytes_i (beat_bytes_i),
    .beat_resp_i  (resp_e'(beat_resp_i)),
    .fin_ok_o     (fin_ok),
    .fin_bad_o    (fin_bad)
  );

  dma_end_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fin_ok_i    (fin_ok),
    .fin_bad_i   (fin_bad),
    .load_i      (load_i),
    .link_i      (link_i),
    .wb_en_i     (wb_en_i),
    .wb_done_i   (wb_done_i),
    .desc_done_i (desc_done_i),
    .desc_vld_i  (desc_vld_i),
    .desc_mask_i (desc_mask_i),
    .end_mask_i  (end_mask_i),
    .clr_end_i   (clr_end_i),
    .clr_der_i   (clr_der_i),
    .clr_err_i   (clr_err_i),
    .end_o       (end_o),
    .der_o       (der_o),
    .err_o       (err_o),
    .irq_o       (irq_o)
  );

  p_fin_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fin_ok && fin_bad));
endmodule

// File: rtl/dma_end_irq_top.sv
module dma_end_irq_top
  import dma_end_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 20,
  parameter int BEAT_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          load_i,
  input  logic [NUM_CH*CNT_W-1:0]    load_cnt_i,
  input  logic [NUM_CH-1:0]          beat_vld_i,
  input  logic [NUM_CH*BEAT_W-1:0]   beat_bytes_i,
  input  logic [NUM_CH*RESP_W-1:0]   beat_resp_i,
  input  logic [NUM_CH-1:0]          link_i,
  input  logic [NUM_CH-1:0]          wb_en_i,
  input  logic [NUM_CH-1:0]          wb_done_i,
  input  logic [NUM_CH-1:0]          desc_done_i,
  input  logic [NUM_CH-1:0]          desc_vld_i,
  input  logic [NUM_CH-1:0]          desc_mask_i,
  input  logic [NUM_CH-1:0]          end_mask_i,
  input  logic [NUM_CH-1:0]          clr_end_i,
  input  logic [NUM_CH-1:0]          clr_der_i,
  input  logic [NUM_CH-1:0]          clr_err_i,
  output logic [NUM_CH-1:0]          end_o,
  output logic [NUM_CH-1:0]          der_o,
  output logic [NUM_CH-1:0]          err_o,
  output logic [NUM_CH-1:0]          irq_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_end_chan #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (load_i[c]),
      .load_cnt_i   (load_cnt_i[c*CNT_W +: CNT_W]),
      .beat_vld_i   (beat_vld_i[c]),
      .beat_bytes_i (beat_bytes_i[c*BEAT_W +: BEAT_W]),
      .beat_resp_i  (beat_resp_i[c*RESP_W +: RESP_W]),
      .link_i       (link_i[c]),
      .wb_en_i      (wb_en_i[c]),
      .wb_done_i    (wb_done_i[c]),
      .desc_done_i  (desc_done_i[c]),
      .desc_vld_i   (desc_vld_i[c]),
      .desc_mask_i  (desc_mask_i[c]),
      .end_mask_i   (end_mask_i[c]),
      .clr_end_i    (clr_end_i[c]),
      .clr_der_i    (clr_der_i[c]),
      .clr_err_i    (clr_err_i[c]),
      .end_o        (end_o[c]),
      .der_o        (der_o[c]),
      .err_o        (err_o[c]),
      .irq_o        (irq_o[c])
    );
  end

  p_reset_clean_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (end_o == '0) && (der_o == '0) && (err_o == '0));
endmodule

// File: tb/dma_end_irq_top_tb_top.sv
module dma_end_irq_top_tb_top;
  localparam int NUM_CH = 16;
  localparam int CNT_W  = 20;
  localparam int BEAT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NUM_CH-1:0]        load_v = '0, beat_v = '0, link_v = '0, wb_en_v = '0, wb_done_v = '0;
  logic [NUM_CH-1:0]        desc_v = '0, lv_v = '0, dim_v = '0, dem_v = '0;
  logic [NUM_CH-1:0]        clr_end_v = '0, clr_der_v = '0, clr_err_v = '0;
  logic [NUM_CH*CNT_W-1:0]  load_cnt_v = '0;
  logic [NUM_CH*BEAT_W-1:0] bytes_v = '0;
  logic [NUM_CH*2-1:0]      resp_v = '0;
  logic [NUM_CH-1:0]        end_w, der_w, err_w, irq_w;

  int n_chk = 0;
  int n_err = 0;

  dma_end_irq_top #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .load_i(load_v), .load_cnt_i(load_cnt_v),
    .beat_vld_i(beat_v), .beat_bytes_i(bytes_v), .beat_resp_i(resp_v),
    .link_i(link_v), .wb_en_i(wb_en_v), .wb_done_i(wb_done_v),
    .desc_done_i(desc_v), .desc_vld_i(lv_v), .desc_mask_i(dim_v),
    .end_mask_i(dem_v),
    .clr_end_i(clr_end_v), .clr_der_i(clr_der_v), .clr_err_i(clr_err_v),
    .end_o(end_w), .der_o(der_w), .err_o(err_w), .irq_o(irq_w)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one clock edge, then drop all pulse inputs
  task automatic step();
    @(negedge clk);
    load_v = '0; beat_v = '0; wb_done_v = '0; desc_v = '0;
    clr_end_v = '0; clr_der_v = '0; clr_err_v = '0;
  endtask

  task automatic load(input int ch, input int cnt);
    load_v[ch] = 1'b1;
    load_cnt_v[ch*CNT_W +: CNT_W] = CNT_W'(cnt);
    step();
  endtask

  task automatic beat(input int ch, input int nb, input logic [1:0] rsp, input logic clr);
    beat_v[ch] = 1'b1;
    bytes_v[ch*BEAT_W +: BEAT_W] = BEAT_W'(nb);
    resp_v[ch*2 +: 2] = rsp;
    clr_end_v[ch] = clr;
    step();
  endtask

  task automatic t_reset();
    chk("R1 end", 32'(end_w), 0);
    chk("R1 der", 32'(der_w), 0);
    chk("R1 err", 32'(err_w), 0);
    chk("R1 irq", 32'(irq_w), 0);
  endtask

  task automatic t_basic();
    load(0, 10);
    beat(0, 4, 2'b00, 1'b0);
    beat(0, 4, 2'b00, 1'b0);
    chk("R2 partial", 32'(end_w[0]), 0);
    beat(0, 2, 2'b00, 1'b0);
    chk("R2 exact total", 32'(end_w[0]), 1);
    chk("R11 only ch0", 32'(end_w), 32'h1);
    chk("R4 irq unmasked", 32'(irq_w[0]), 1);
    dem_v[0] = 1'b1; #1;
    chk("R4 irq masked", 32'(irq_w[0]), 0);
    dem_v[0] = 1'b0;
    step(); step(); step();
    chk("R10 end held", 32'(end_w[0]), 1);
    chk("R10 irq held", 32'(irq_w[0]), 1);
    clr_end_v[0] = 1'b1; step();
    chk("R10 cleared", 32'(end_w[0]), 0);
    load(0, 5);
    beat(0, 8, 2'b00, 1'b0);
    chk("R2 overshoot", 32'(end_w[0]), 1);
    clr_end_v[0] = 1'b1; step();
  endtask

  task automatic t_error();
    load(1, 4);
    beat(1, 4, 2'b10, 1'b0);
    chk("R3 err set", 32'(err_w[1]), 1);
    chk("R3 no end", 32'(end_w[1]), 0);
    clr_err_v[1] = 1'b1; step();
    chk("R3 err clr", 32'(err_w[1]), 0);
  endtask

  task automatic t_writeback();
    link_v[2] = 1'b1; wb_en_v[2] = 1'b1;
    load(2, 8);
    beat(2, 8, 2'b00, 1'b0);
    chk("R5 deferred", 32'(end_w[2]), 0);
    step(); step();
    chk("R5 still deferred", 32'(end_w[2]), 0);
    wb_done_v[2] = 1'b1; step();
    chk("R5 after writeback", 32'(end_w[2]), 1);
    link_v[3] = 1'b1; wb_en_v[3] = 1'b1;
    wb_done_v[3] = 1'b1; step();
    chk("R5 spurious writeback", 32'(end_w[3]), 0);
  endtask

  task automatic t_desc();
    link_v[4] = 1'b1;
    desc_v[4] = 1'b1; lv_v[4] = 1'b0; dim_v[4] = 1'b0; step();
    chk("R6 der set", 32'(der_w[4]), 1);
    chk("R7 irq dim0", 32'(irq_w[4]), 1);
    clr_der_v[4] = 1'b1; step();
    chk("R6 der clr", 32'(der_w[4]), 0);
    desc_v[4] = 1'b1; lv_v[4] = 1'b0; dim_v[4] = 1'b1; step();
    chk("R6 der set masked", 32'(der_w[4]), 1);
    chk("R7 irq dim1", 32'(irq_w[4]), 0);
    clr_der_v[4] = 1'b1; step();
    desc_v[4] = 1'b1; lv_v[4] = 1'b1; dim_v[4] = 1'b0; step();
    chk("R6 valid header", 32'(der_w[4]), 0);
    desc_v[5] = 1'b1; lv_v[5] = 1'b0; dim_v[5] = 1'b0; step();
    chk("R6 not link", 32'(der_w[5]), 0);
  endtask

  task automatic t_reload();
    load(0, 2);
    beat(0, 2, 2'b00, 1'b0);
    load(0, 10);
    chk("R8 status kept", 32'(end_w[0]), 1);
    beat(0, 6, 2'b00, 1'b0);
    load(0, 6);
    clr_end_v[0] = 1'b1; step();
    beat(0, 4, 2'b00, 1'b0);
    chk("R8 count restarted", 32'(end_w[0]), 0);
    beat(0, 2, 2'b00, 1'b0);
    chk("R8 new total", 32'(end_w[0]), 1);
  endtask

  task automatic t_priority();
    load(6, 4);
    beat(6, 4, 2'b00, 1'b1);
    chk("R9 current set wins", 32'(end_w[6]), 1);
    link_v[7] = 1'b1; wb_en_v[7] = 1'b1;
    load(7, 4);
    beat(7, 4, 2'b00, 1'b0);
    load(7, 8);
    wb_done_v[7] = 1'b1; clr_end_v[7] = 1'b1; step();
    chk("R9 stale clear wins", 32'(end_w[7]), 0);
  endtask

  task automatic t_ignore();
    beat(8, 16, 2'b00, 1'b0);
    chk("R12 unarmed end", 32'(end_w[8]), 0);
    beat(8, 16, 2'b10, 1'b0);
    chk("R12 unarmed err", 32'(err_w[8]), 0);
    load(8, 4);
    beat(8, 4, 2'b00, 1'b0);
    clr_end_v[8] = 1'b1; step();
    beat(8, 4, 2'b00, 1'b0);
    chk("R12 after done", 32'(end_w[8]), 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_error();
    t_writeback();
    t_desc();
    t_reload();
    t_priority();
    t_ignore();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule